// File: doc/BRIEF.md
# Dual-Phase Receive Frame Sequencer

This block is the receive half of a frame-synchronised serial port. On every rising edge of the receive clock it samples one data bit, most significant bit first, and packs the bits into fixed-width words. A frame-sync pulse starts a frame. The first data bit is taken on the clock edge after the sync, with no added delay. A frame is made of one phase or of two phases. Each phase has its own programmable word count, and phase 1 is always received before phase 2.

Every completed word is presented for one cycle on a valid strobe, together with a flag that tells which phase the word belongs to. The last word of the frame also raises an end-of-frame strobe. A sync pulse that arrives while a frame is still incomplete is a premature sync. A policy input decides what happens to it. It is either ignored, or it aborts the partial word, restarts the frame and sets a sticky error flag, which stays set until a dedicated clear input removes it.

Top module: `rx_frame_sequencer`

## Requirements
- R1: While reset is asserted, and right after it is released, `wordValid`, `frameEnd`, `wordPhase`, `syncErr` and `wordData` are all 0.
- R2: After a sync is sampled, the next WORD_W clock edges sample `serIn`, and the first of these bits becomes bit WORD_W-1 of the word. `wordValid` is high for exactly one cycle, after the edge that samples the last bit, and `wordData` holds the word in that cycle.
- R3: A phase length field of value N (7 bits, 0 to 127) gives N+1 words in that phase, so 127 gives 128 words.
- R4: With `dualPhase` = 0 the frame holds `phase1Len`+1 words and every word reports `wordPhase` = 0. The value of `phase2Len` has no effect.
- R5: With `dualPhase` = 1 the frame holds `phase1Len`+1 words with `wordPhase` = 0, followed by `phase2Len`+1 words with `wordPhase` = 1.
- R6: `frameEnd` pulses in the same cycle as `wordValid` for the last word of the frame, and never at any other time.
- R7: While no frame is in progress, `serIn` produces no words. A sync in that state starts a frame and never sets `syncErr`.
- R8: A sync sampled on the same edge as the last bit of a frame is a normal start. The frame completes with `frameEnd`, and the next frame's first bit is sampled on the following edge with no error.
- R9: With `ignoreSync` = 1, a sync during an incomplete frame has no effect. Every word of the frame is received unchanged, and `syncErr` stays 0.
- R10: With `ignoreSync` = 0, a sync during an incomplete frame discards the partial word and emits no word for it. It sets `syncErr` and starts a new frame whose first bit is sampled on the next edge.
- R11: `syncErr` stays set until `errClear` is sampled high. If a new error occurs on the same edge as a clear, `syncErr` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| serIn | input | 1 | Serial data bit |
| syncIn | input | 1 | Frame-sync pulse, sampled on the rising edge |
| dualPhase | input | 1 | 0: single-phase frame, 1: dual-phase frame |
| phase1Len | input | 7 | Phase 1 word count minus one |
| phase2Len | input | 7 | Phase 2 word count minus one |
| ignoreSync | input | 1 | 1: ignore premature syncs, 0: abort and restart |
| errClear | input | 1 | Clears the sticky sync error |
| wordValid | output | 1 | One-cycle strobe for a received word |
| wordData | output | WORD_W | Received word, valid while wordValid is high |
| wordPhase | output | 1 | Phase of the current word (0: phase 1, 1: phase 2) |
| frameEnd | output | 1 | Pulses with the last word of the frame |
| syncErr | output | 1 | Sticky premature-sync error flag |

## Verification
The bench drives the inputs on falling edges, so a sync seen at rising edge k is followed by the first data bit at edge k+1. The word whose last bit is sampled at edge k+WORD_W shows `wordValid` and `frameEnd` from that edge until the next one. A collector therefore reads the outputs on the falling edge that follows each rising edge. Frame contents are compared only after a few idle cycles, so the final word has had time to arrive. `syncErr` changes on the edge that samples the offending sync or the clear, and it is checked at the falling edge after that. The sweep covers both phase modes and several lengths, including the 128-word limit, and it computes every expected word, phase flag and end flag from the sequence it sent.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  localparam int LEN_W = 7;

  typedef struct packed {
    logic clearShift;
    logic shiftEn;
    logic emit;
    logic emitPhase;
    logic emitEnd;
  } rxStrobe_t;

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             dualPhase,
  input  logic [LEN_W-1:0] phase1Len,
  input  logic [LEN_W-1:0] phase2Len,
  input  logic             ignoreSync,
  input  logic             errClear,
  output rxStrobe_t        strobe,
  output logic             syncErr
);

  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic             active;
  logic [BIT_W-1:0] bitCnt;
  logic [LEN_W-1:0] wordCnt;
  logic             phase;

  logic [LEN_W-1:0] curLen;
  logic             lastBit;
  logic             lastWord;
  logic             finalPhase;
  logic             frameLast;
  logic             premature;
  logic             abortNow;
  logic             startNow;

  always_comb begin
    curLen     = phase ? phase2Len : phase1Len;
    lastBit    = (bitCnt == LAST_BIT);
    lastWord   = (wordCnt == curLen);
    finalPhase = phase || !dualPhase;
    frameLast  = active && lastBit && lastWord && finalPhase;
    premature  = syncIn && active && !frameLast;
    abortNow   = premature && !ignoreSync;
    startNow   = syncIn && (!active || frameLast || !ignoreSync);
  end

  always_comb begin
    strobe.clearShift = startNow;
    strobe.shiftEn    = active && !abortNow;
    strobe.emit       = active && lastBit && !abortNow;
    strobe.emitPhase  = phase;
    strobe.emitEnd    = frameLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      bitCnt  <= '0;
      wordCnt <= '0;
      phase   <= 1'b0;
    end else if (startNow) begin
      active  <= 1'b1;
      bitCnt  <= '0;
      wordCnt <= '0;
      phase   <= 1'b0;
    end else if (active) begin
      if (lastBit) begin
        bitCnt <= '0;
        if (lastWord) begin
          wordCnt <= '0;
          if (finalPhase) begin
            active <= 1'b0;
            phase  <= 1'b0;
          end else begin
            phase <= 1'b1;
          end
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncErr <= 1'b0;
    end else if (abortNow) begin
      syncErr <= 1'b1;
    end else if (errClear) begin
      syncErr <= 1'b0;
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncErr && !errClear |=> syncErr);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncErr) |-> $past(syncIn) && !$past(ignoreSync));

  // R7
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active && !syncErr |=> !syncErr);

  // R4
  phase_two_dual_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && phase |-> dualPhase);

  // R3
  word_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> wordCnt <= curLen);

endmodule

// File: rtl/rx_word_dpath.sv
module rx_word_dpath
  import rx_frame_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  rxStrobe_t         strobe,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic              wordPhase,
  output logic              frameEnd
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[WORD_W-2:0], serIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      frameEnd  <= 1'b0;
      wordPhase <= 1'b0;
      wordData  <= '0;
    end else begin
      wordValid <= strobe.emit;
      frameEnd  <= strobe.emit && strobe.emitEnd;
      if (strobe.emit) begin
        wordData  <= shiftNext;
        wordPhase <= strobe.emitPhase;
      end
    end
  end

  // R6
  end_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> wordValid);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

endmodule

// File: rtl/rx_frame_sequencer.sv
module rx_frame_sequencer
  import rx_frame_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              syncIn,
  input  logic              dualPhase,
  input  logic [6:0]        phase1Len,
  input  logic [6:0]        phase2Len,
  input  logic              ignoreSync,
  input  logic              errClear,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic              wordPhase,
  output logic              frameEnd,
  output logic              syncErr
);

  rxStrobe_t strobe;

  rx_frame_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .dualPhase  (dualPhase),
    .phase1Len  (phase1Len),
    .phase2Len  (phase2Len),
    .ignoreSync (ignoreSync),
    .errClear   (errClear),
    .strobe     (strobe),
    .syncErr    (syncErr)
  );

  rx_word_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .strobe    (strobe),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordPhase (wordPhase),
    .frameEnd  (frameEnd)
  );

endmodule

// File: tb/tb_rx_frame_sequencer.sv
module tb_rx_frame_sequencer;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic syncIn = 1'b0;
  logic dualPhase = 1'b0;
  logic [6:0] phase1Len = '0;
  logic [6:0] phase2Len = '0;
  logic ignoreSync = 1'b0;
  logic errClear = 1'b0;
  logic wordValid;
  logic [W-1:0] wordData;
  logic wordPhase;
  logic frameEnd;
  logic syncErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] gotData [0:1023];
  logic gotPhase [0:1023];
  logic gotEnd [0:1023];
  int gotN = 0;

  always #4 clk = ~clk;

  rx_frame_sequencer #(.WORD_W(W)) dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .syncIn(syncIn),
    .dualPhase(dualPhase), .phase1Len(phase1Len), .phase2Len(phase2Len),
    .ignoreSync(ignoreSync), .errClear(errClear),
    .wordValid(wordValid), .wordData(wordData), .wordPhase(wordPhase),
    .frameEnd(frameEnd), .syncErr(syncErr)
  );

  always @(negedge clk) begin
    if (rstN && wordValid && gotN < 1024) begin
      gotData[gotN]  = wordData;
      gotPhase[gotN] = wordPhase;
      gotEnd[gotN]   = frameEnd;
      gotN = gotN + 1;
    end
  end

  function automatic logic [W-1:0] wordVal(input int seed, input int idx);
    return W'(seed * 53 + idx * 29 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      syncIn = 1'b0;
      serIn = i[0];
    end
  endtask

  task automatic startFrame();
    @(negedge clk);
    syncIn = 1'b1;
    serIn = 1'b1;
  endtask

  // sends all bits of a frame; optional sync on last bit or at a global bit index
  task automatic sendBody(input bit dual, input int l1, input int l2, input int seed,
                          input bit syncAtEnd, input int injectAt);
    int n;
    int g;
    n = (l1 + 1) + (dual ? (l2 + 1) : 0);
    g = 0;
    for (int w = 0; w < n; w++) begin
      logic [W-1:0] v;
      v = wordVal(seed, w);
      for (int b = W - 1; b >= 0; b--) begin
        @(negedge clk);
        serIn = v[b];
        syncIn = (syncAtEnd && w == n - 1 && b == 0) || (g == injectAt);
        g++;
      end
    end
  endtask

  // compares collected words starting at base against the expected frame
  task automatic checkFrame(input int base, input bit dual, input int l1, input int l2,
                            input int seed, input string tagData, input string tagPh);
    int n;
    int badD, badP, badE;
    int firstAct, firstExp;
    n = (l1 + 1) + (dual ? (l2 + 1) : 0);
    badD = 0; badP = 0; badE = 0; firstAct = 0; firstExp = 0;
    for (int w = 0; w < n; w++) begin
      logic expPh;
      logic expEnd;
      expPh = (w > l1) ? 1'b1 : 1'b0;
      expEnd = (w == n - 1);
      if (gotData[base + w] !== wordVal(seed, w)) begin
        if (badD == 0) begin
          firstAct = int'(gotData[base + w]);
          firstExp = int'(wordVal(seed, w));
        end
        badD++;
      end
      if (gotPhase[base + w] !== expPh) badP++;
      if (gotEnd[base + w] !== expEnd) badE++;
    end
    chk(badD == 0, tagData, firstAct, firstExp);
    chk(badP == 0, tagPh, badP, 0);
    chk(badE == 0, "R6 frameEnd placement", badE, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(wordValid == 0 && frameEnd == 0 && wordPhase == 0 && syncErr == 0 && wordData == 0,
        "R1 reset outputs", int'(wordValid) + int'(syncErr) + int'(wordData), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(wordValid == 0 && syncErr == 0, "R1 after release", int'(wordValid) + int'(syncErr), 0);

    // R7 idle data produces nothing
    base = gotN;
    idle(40);
    chk(gotN == base, "R7 idle words", gotN - base, 0);
    chk(syncErr == 0, "R7 idle error", int'(syncErr), 0);

    // sweep: R2 R3 R4 R5
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 3; c++) begin
          int l1v, l2v, sd;
          l1v = (a == 3) ? 5 : a;
          l2v = c * 2;
          sd = d * 100 + a * 10 + c;
          dualPhase = d[0];
          phase1Len = 7'(l1v);
          phase2Len = 7'(l2v);
          base = gotN;
          startFrame();
          sendBody(d[0], l1v, l2v, sd, 1'b0, -1);
          idle(4);
          n = (l1v + 1) + (d == 1 ? (l2v + 1) : 0);
          chk(gotN - base == n, d == 1 ? "R5 dual word count" : "R4 single word count",
              gotN - base, n);
          checkFrame(base, d[0], l1v, l2v, sd, "R2 word data",
                     d == 1 ? "R5 phase flags" : "R4 phase flags");
          chk(syncErr == 0, "R7 normal start no error", int'(syncErr), 0);
        end
      end
    end

    // R3 maximum length in both phases
    dualPhase = 1'b1; phase1Len = 7'd127; phase2Len = 7'd127;
    base = gotN;
    startFrame();
    sendBody(1'b1, 127, 127, 77, 1'b0, -1);
    idle(4);
    chk(gotN - base == 256, "R3 max length count", gotN - base, 256);
    checkFrame(base, 1'b1, 127, 127, 77, "R3 max length data", "R5 max length phases");

    // R8 back-to-back frames, sync on last bit
    dualPhase = 1'b1; phase1Len = 7'd1; phase2Len = 7'd2;
    base = gotN;
    startFrame();
    sendBody(1'b1, 1, 2, 21, 1'b1, -1);
    sendBody(1'b1, 1, 2, 22, 1'b0, -1);
    idle(4);
    chk(gotN - base == 10, "R8 back-to-back count", gotN - base, 10);
    checkFrame(base, 1'b1, 1, 2, 21, "R8 first frame data", "R8 first frame phases");
    checkFrame(base + 5, 1'b1, 1, 2, 22, "R8 second frame data", "R8 second frame phases");
    chk(syncErr == 0, "R8 no error", int'(syncErr), 0);

    // R9 premature sync ignored
    ignoreSync = 1'b1; dualPhase = 1'b0; phase1Len = 7'd3; phase2Len = 7'd9;
    base = gotN;
    startFrame();
    sendBody(1'b0, 3, 9, 33, 1'b0, 10);
    idle(4);
    chk(gotN - base == 4, "R9 ignore count", gotN - base, 4);
    checkFrame(base, 1'b0, 3, 9, 33, "R9 ignore data", "R9 ignore phases");
    chk(syncErr == 0, "R9 no error", int'(syncErr), 0);

    // R10 premature sync aborts and restarts
    ignoreSync = 1'b0; dualPhase = 1'b0; phase1Len = 7'd1;
    base = gotN;
    startFrame();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      syncIn = 1'b0;
      serIn = 1'b1;
    end
    @(negedge clk);
    syncIn = 1'b1;
    serIn = 1'b0;
    @(negedge clk);
    chk(gotN == base, "R10 partial word discarded", gotN - base, 0);
    chk(syncErr == 1, "R10 error set", int'(syncErr), 1);
    // the frame already restarted: this edge is its first bit
    syncIn = 1'b0;
    begin
      logic [W-1:0] v0;
      v0 = wordVal(44, 0);
      serIn = v0[W-1];
      for (int b = W - 2; b >= 0; b--) begin
        @(negedge clk);
        serIn = v0[b];
      end
      v0 = wordVal(44, 1);
      for (int b = W - 1; b >= 0; b--) begin
        @(negedge clk);
        serIn = v0[b];
      end
    end
    idle(4);
    chk(gotN - base == 2, "R10 restarted frame count", gotN - base, 2);
    checkFrame(base, 1'b0, 1, 0, 44, "R10 restarted frame data", "R10 restarted phases");

    // R11 sticky then cleared
    idle(10);
    chk(syncErr == 1, "R11 error sticky", int'(syncErr), 1);
    @(negedge clk);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk(syncErr == 0, "R11 error cleared", int'(syncErr), 0);

    // R11 set wins over clear on the same edge
    startFrame();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      syncIn = 1'b0;
      serIn = 1'b0;
    end
    @(negedge clk);
    syncIn = 1'b1;
    errClear = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    errClear = 1'b0;
    @(negedge clk);
    chk(syncErr == 1, "R11 set beats clear", int'(syncErr), 1);
    idle(2 * W + 4);
    @(negedge clk);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk(syncErr == 0, "R11 final clear", int'(syncErr), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule